// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Key-Based Access Control

This block turns a 64-bit virtual address into a physical address and decides whether the requested access may proceed. The three most significant address bits pick one of eight region registers. The region ID held there, together with the virtual page bits, is compared against every translation entry at once. Each entry carries a physical page number, its own page size, a rights mask and a protection key. Because the tag is a region ID and not a per-process identifier, two contexts that load the same region ID see the same entries.

When key checking is switched on, the key that belongs to the hit entry is searched for among a small set of key registers. The rights of the matching register are ANDed with the entry's rights. A key register can therefore allow writes while forbidding reads, and the same entry can serve contexts that hold different key registers. A second option takes the key from the region ID instead of the entry. This serves page tables whose entries have no key field.

Software fills entries through a write port with round-robin victim choice. It can drop an entry by region ID and page, and it loads region and key registers through their own write ports. Each lookup answers one cycle after the request.

Top module: `rtlb_top`

## Requirements
- R1: Bits [63:61] of `req_va` select the region register. Its region ID must equal an entry's region ID for that entry to hit. After reset all region registers hold ID 0.
- R2: An entry with page-size code ps (log2 of the page size, 12 to 32) hits when VA bits [60:ps] equal its stored page bits. The result address takes bits below ps from the VA and the bits above from the entry's page number.
- R3: A response (`rsp_valid` high) appears exactly one cycle after each cycle with `req_valid` high, and at no other time.
- R4: `rsp_fault` codes are 0 none, 1 translation miss, 2 key miss and 3 rights violation. When several apply, the first in that list after "none" wins. `rsp_hit` is high exactly when some entry matched.
- R5: The access code is 0 for read (rights bit 0), 1 for write (bit 1), 2 for execute (bit 2) and 3 for read. With key checking off, the access is allowed when the entry's rights bit is set.
- R6: With `key_chk_en` high, the key is compared with every valid key register. No match gives fault 2. On a match the permitted set is entry rights AND register rights, so a register with only the write bit gives write-only access.
- R7: With `key_from_region` high, the key used in R6 is the low key-width bits of the selected region ID, and the entry's key is not used.
- R8: Two regions loaded with the same region ID reach the same entries with identical results.
- R9: Entry writes fill slots in round-robin order starting at slot 0 after reset. The ninth write (with 8 entries) overwrites the first.
- R10: A purge removes every entry whose region ID matches and whose page, at the entry's own size, covers the purge page bits. Other entries are unaffected.
- R11: Reset invalidates all entries and key registers and clears `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 read |
| key_chk_en | input | 1 | Enables key-register checking |
| key_from_region | input | 1 | Takes the key from the region ID instead of the entry |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_pa | output | 48 | Physical address |
| rsp_fault | output | 2 | Fault code |
| tw_en | input | 1 | Entry write strobe |
| tw_rid | input | 16 | Region ID of the new entry |
| tw_vpage | input | 49 | VA bits [60:12] of the new entry |
| tw_ps | input | 6 | Page-size code (log2 bytes) |
| tw_ppn | input | 36 | Physical page number (PA bits [47:12]) |
| tw_rights | input | 3 | Entry rights {exec, write, read} |
| tw_key | input | 16 | Entry protection key |
| pg_en | input | 1 | Purge strobe |
| pg_rid | input | 16 | Region ID to purge |
| pg_vpage | input | 49 | VA bits [60:12] to purge |
| rr_we | input | 1 | Region register write strobe |
| rr_idx | input | 3 | Region register index |
| rr_rid | input | 16 | Region ID to store |
| kw_en | input | 1 | Key register write strobe |
| kw_idx | input | 2 | Key register index |
| kw_valid | input | 1 | Valid bit to store |
| kw_key | input | 16 | Key to store |
| kw_rights | input | 3 | Key register rights {exec, write, read} |

## Verification
The bench maps a 4 GB page as well as 4 KB pages. A design that masked the compare with a fixed size would miss on the large page or would splice the wrong offset bits into the address. Key tests use a write-only key register on a read-write entry, so a design that ORed the rights instead of ANDing them would wrongly grant the read. Other tests check that a missing key is reported differently from a missing translation, and that a translation miss wins when both apply. A region loaded with an ID that another region already uses must hit the shared entry. A purge must spare a neighbouring entry. The round-robin test wraps the victim pointer and checks that the oldest entry is evicted and the newest survives.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
   localparam int RIGHTS_W = 3;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_TLB_MISS = 2'd1,
      FLT_KEY_MISS = 2'd2,
      FLT_RIGHTS   = 2'd3
   } rtlb_fault_e;
endpackage

// File: rtl/rtlb_region_file.sv
module rtlb_region_file #(
   parameter int REG_BITS = 3,
   parameter int RID_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [REG_BITS-1:0] wr_idx,
   input  logic [RID_W-1:0]    wr_rid,
   input  logic [REG_BITS-1:0] rd_idx,
   output logic [RID_W-1:0]    rd_rid
);
   localparam int NREG = 1 << REG_BITS;

   logic [RID_W-1:0] rid_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) rid_q[i] <= '0;
      end else if (we) begin
         rid_q[wr_idx] <= wr_rid;
      end
   end

   assign rd_rid = rid_q[rd_idx];
endmodule

// File: rtl/rtlb_key_file.sv
module rtlb_key_file #(
   parameter int NKEYS = 4,
   parameter int KEY_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(NKEYS)-1:0]   wr_idx,
   input  logic                       wr_valid,
   input  logic [KEY_W-1:0]           wr_key,
   input  logic [rtlb_pkg::RIGHTS_W-1:0] wr_rights,
   input  logic [KEY_W-1:0]           lk_key,
   output logic                       lk_hit,
   output logic [rtlb_pkg::RIGHTS_W-1:0] lk_rights
);
   localparam int RW = rtlb_pkg::RIGHTS_W;

   logic [NKEYS-1:0] kv_q;
   logic [KEY_W-1:0] key_q [NKEYS];
   logic [RW-1:0]    rgt_q [NKEYS];
   logic [NKEYS-1:0] match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kv_q <= '0;
         for (int i = 0; i < NKEYS; i++) begin
            key_q[i] <= '0;
            rgt_q[i] <= '0;
         end
      end else if (we) begin
         kv_q[wr_idx]  <= wr_valid;
         key_q[wr_idx] <= wr_key;
         rgt_q[wr_idx] <= wr_rights;
      end
   end

   for (genvar g = 0; g < NKEYS; g++) begin : g_kcmp
      assign match[g] = kv_q[g] && (key_q[g] == lk_key);
   end

   always_comb begin
      lk_hit    = 1'b0;
      lk_rights = '0;
      for (int i = NKEYS - 1; i >= 0; i--) begin
         if (match[i]) begin
            lk_hit    = 1'b1;
            lk_rights = rgt_q[i];
         end
      end
   end
endmodule

// File: rtl/rtlb_entry_array.sv
module rtlb_entry_array #(
   parameter int ENTRIES = 8,
   parameter int RID_W   = 16,
   parameter int KEY_W   = 16,
   parameter int PPN_W   = 36,
   parameter int TAG_W   = 49,
   parameter int PS_W    = 6,
   parameter int MIN_PS  = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [RID_W-1:0]              wr_rid,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic [PS_W-1:0]               wr_ps,
   input  logic [PPN_W-1:0]              wr_ppn,
   input  logic [rtlb_pkg::RIGHTS_W-1:0] wr_rights,
   input  logic [KEY_W-1:0]              wr_key,
   input  logic                          pg_en,
   input  logic [RID_W-1:0]              pg_rid,
   input  logic [TAG_W-1:0]              pg_tag,
   input  logic [RID_W-1:0]              lk_rid,
   input  logic [TAG_W-1:0]              lk_tag,
   output logic                          lk_hit,
   output logic [PPN_W-1:0]              lk_ppn,
   output logic [PS_W-1:0]               lk_ps,
   output logic [rtlb_pkg::RIGHTS_W-1:0] lk_rights,
   output logic [KEY_W-1:0]              lk_key
);
   localparam int RW    = rtlb_pkg::RIGHTS_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] ev_q;
   logic [RID_W-1:0]   rid_q [ENTRIES];
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PS_W-1:0]    ps_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic [RW-1:0]      rgt_q [ENTRIES];
   logic [KEY_W-1:0]   key_q [ENTRIES];
   logic [IDX_W-1:0]   vic_q;
   logic [ENTRIES-1:0] lk_vec;
   logic [ENTRIES-1:0] pg_vec;

   // Per-entry compare: only page bits at or above the entry's size take part.
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [TAG_W-1:0] care;
      always_comb begin
         for (int j = 0; j < TAG_W; j++) care[j] = (j + MIN_PS) >= int'(ps_q[g]);
      end
      assign lk_vec[g] = ev_q[g] && (rid_q[g] == lk_rid) && (((tag_q[g] ^ lk_tag) & care) == '0);
      assign pg_vec[g] = ev_q[g] && (rid_q[g] == pg_rid) && (((tag_q[g] ^ pg_tag) & care) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q  <= '0;
         vic_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (pg_en && pg_vec[i]) ev_q[i] <= 1'b0;
         end
         if (wr_en) begin
            ev_q[vic_q] <= 1'b1;
            vic_q       <= (vic_q == LAST) ? '0 : vic_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         rid_q[vic_q] <= wr_rid;
         tag_q[vic_q] <= wr_tag;
         ps_q[vic_q]  <= wr_ps;
         ppn_q[vic_q] <= wr_ppn;
         rgt_q[vic_q] <= wr_rights;
         key_q[vic_q] <= wr_key;
      end
   end

   always_comb begin
      lk_hit    = 1'b0;
      lk_ppn    = '0;
      lk_ps     = PS_W'(MIN_PS);
      lk_rights = '0;
      lk_key    = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_vec[i]) begin
            lk_hit    = 1'b1;
            lk_ppn    = ppn_q[i];
            lk_ps     = ps_q[i];
            lk_rights = rgt_q[i];
            lk_key    = key_q[i];
         end
      end
   end
endmodule

// File: rtl/rtlb_top.sv
module rtlb_top #(
   parameter int VA_W     = 64,
   parameter int PA_W     = 48,
   parameter int REG_BITS = 3,
   parameter int RID_W    = 16,
   parameter int KEY_W    = 16,
   parameter int ENTRIES  = 8,
   parameter int NKEYS    = 4,
   parameter int MIN_PS   = 12,
   parameter int MAX_PS   = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic [VA_W-1:0]                   req_va,
   input  logic [1:0]                        req_acc,
   input  logic                              key_chk_en,
   input  logic                              key_from_region,
   output logic                              rsp_valid,
   output logic                              rsp_hit,
   output logic [PA_W-1:0]                   rsp_pa,
   output logic [1:0]                        rsp_fault,
   input  logic                              tw_en,
   input  logic [RID_W-1:0]                  tw_rid,
   input  logic [VA_W-REG_BITS-MIN_PS-1:0]   tw_vpage,
   input  logic [$clog2(MAX_PS+1)-1:0]       tw_ps,
   input  logic [PA_W-MIN_PS-1:0]            tw_ppn,
   input  logic [2:0]                        tw_rights,
   input  logic [KEY_W-1:0]                  tw_key,
   input  logic                              pg_en,
   input  logic [RID_W-1:0]                  pg_rid,
   input  logic [VA_W-REG_BITS-MIN_PS-1:0]   pg_vpage,
   input  logic                              rr_we,
   input  logic [REG_BITS-1:0]               rr_idx,
   input  logic [RID_W-1:0]                  rr_rid,
   input  logic                              kw_en,
   input  logic [$clog2(NKEYS)-1:0]          kw_idx,
   input  logic                              kw_valid,
   input  logic [KEY_W-1:0]                  kw_key,
   input  logic [2:0]                        kw_rights
);
   import rtlb_pkg::*;

   localparam int TAG_W = VA_W - REG_BITS - MIN_PS;
   localparam int PPN_W = PA_W - MIN_PS;
   localparam int PS_W  = $clog2(MAX_PS + 1);

   // Elaboration-time parameter checks
   if (MIN_PS > MAX_PS) begin : g_bad_ps
      $error("rtlb_top: MIN_PS must not exceed MAX_PS");
   end
   if (MAX_PS > PA_W) begin : g_bad_pa
      $error("rtlb_top: MAX_PS must fit in PA_W");
   end
   if (PA_W > VA_W - REG_BITS) begin : g_bad_va
      $error("rtlb_top: PA_W must not exceed the page+offset width");
   end
   if (ENTRIES < 2 || NKEYS < 2) begin : g_bad_cnt
      $error("rtlb_top: ENTRIES and NKEYS must be at least 2");
   end

   logic [REG_BITS-1:0] rsel;
   logic [TAG_W-1:0]    lk_tag;
   logic [RID_W-1:0]    cur_rid;
   logic                e_hit;
   logic [PPN_W-1:0]    e_ppn;
   logic [PS_W-1:0]     e_ps;
   logic [RIGHTS_W-1:0] e_rights;
   logic [KEY_W-1:0]    e_key;
   logic [KEY_W-1:0]    rid_key;
   logic [KEY_W-1:0]    use_key;
   logic                k_hit;
   logic [RIGHTS_W-1:0] k_rights;
   logic [RIGHTS_W-1:0] allowed;
   logic [PS_W-1:0]     wr_ps_c;
   logic [PA_W-1:0]     pa_d;
   logic                acc_ok;
   rtlb_fault_e         fault_d;

   assign rsel   = req_va[VA_W-1 -: REG_BITS];
   assign lk_tag = req_va[VA_W-REG_BITS-1 : MIN_PS];

   // Out-of-range size codes are pulled into the supported span.
   always_comb begin
      if (int'(tw_ps) < MIN_PS)      wr_ps_c = PS_W'(MIN_PS);
      else if (int'(tw_ps) > MAX_PS) wr_ps_c = PS_W'(MAX_PS);
      else                           wr_ps_c = tw_ps;
   end

   rtlb_region_file #(.REG_BITS(REG_BITS), .RID_W(RID_W)) i_regions (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rr_we),
      .wr_idx (rr_idx),
      .wr_rid (rr_rid),
      .rd_idx (rsel),
      .rd_rid (cur_rid)
   );

   rtlb_entry_array #(
      .ENTRIES(ENTRIES), .RID_W(RID_W), .KEY_W(KEY_W), .PPN_W(PPN_W),
      .TAG_W(TAG_W), .PS_W(PS_W), .MIN_PS(MIN_PS)
   ) i_entries (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tw_en),
      .wr_rid    (tw_rid),
      .wr_tag    (tw_vpage),
      .wr_ps     (wr_ps_c),
      .wr_ppn    (tw_ppn),
      .wr_rights (tw_rights),
      .wr_key    (tw_key),
      .pg_en     (pg_en),
      .pg_rid    (pg_rid),
      .pg_tag    (pg_vpage),
      .lk_rid    (cur_rid),
      .lk_tag    (lk_tag),
      .lk_hit    (e_hit),
      .lk_ppn    (e_ppn),
      .lk_ps     (e_ps),
      .lk_rights (e_rights),
      .lk_key    (e_key)
   );

   // Key taken from the region ID: truncate or zero-extend as widths demand.
   if (RID_W >= KEY_W) begin : g_rk_trunc
      assign rid_key = cur_rid[KEY_W-1:0];
   end else begin : g_rk_ext
      assign rid_key = {{(KEY_W - RID_W){1'b0}}, cur_rid};
   end

   assign use_key = key_from_region ? rid_key : e_key;

   rtlb_key_file #(.NKEYS(NKEYS), .KEY_W(KEY_W)) i_keys (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (kw_en),
      .wr_idx    (kw_idx),
      .wr_valid  (kw_valid),
      .wr_key    (kw_key),
      .wr_rights (kw_rights),
      .lk_key    (use_key),
      .lk_hit    (k_hit),
      .lk_rights (k_rights)
   );

   assign allowed = key_chk_en ? (e_rights & k_rights) : e_rights;

   always_comb begin
      unique case (req_acc)
         2'd1:    acc_ok = allowed[1];
         2'd2:    acc_ok = allowed[2];
         default: acc_ok = allowed[0];
      endcase
   end

   always_comb begin
      if (!e_hit)                   fault_d = FLT_TLB_MISS;
      else if (key_chk_en && !k_hit) fault_d = FLT_KEY_MISS;
      else if (!acc_ok)             fault_d = FLT_RIGHTS;
      else                          fault_d = FLT_NONE;
   end

   // Offset bits below the entry size come from the VA, the rest from the page.
   always_comb begin
      for (int j = 0; j < PA_W; j++) begin
         if (j < int'(e_ps))   pa_d[j] = req_va[j];
         else if (j < MIN_PS)  pa_d[j] = 1'b0;
         else                  pa_d[j] = e_ppn[j - MIN_PS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pa    <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit   <= e_hit;
            rsp_pa    <= e_hit ? pa_d : '0;
            rsp_fault <= fault_d;
         end
      end
   end
endmodule

// File: rtl/rtlb_checker.sv
module rtlb_checker #(
   parameter int MIN_PS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [MIN_PS-1:0] req_off,
   input logic              key_chk_en,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [MIN_PS-1:0] rsp_off,
   input logic [1:0]        rsp_fault
);
   a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r3_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_fault == 2'd1));

   a_r4_hit_not_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_fault != 2'd1));

   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || (rsp_off == $past(req_off))));

   a_r6_keymiss_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !key_chk_en) |=> (rsp_fault != 2'd2));
endmodule

bind rtlb_top rtlb_checker #(.MIN_PS(MIN_PS)) i_rtlb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_off    (req_va[MIN_PS-1:0]),
   .key_chk_en (key_chk_en),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_off    (rsp_pa[MIN_PS-1:0]),
   .rsp_fault  (rsp_fault)
);

// File: tb/test_rtlb_top.sv
`timescale 1ns/1ps
module test_rtlb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [1:0]  req_acc = '0;
   logic        key_chk_en = 1'b0;
   logic        key_from_region = 1'b0;
   logic        rsp_valid, rsp_hit;
   logic [47:0] rsp_pa;
   logic [1:0]  rsp_fault;
   logic        tw_en = 1'b0;
   logic [15:0] tw_rid = '0;
   logic [48:0] tw_vpage = '0;
   logic [5:0]  tw_ps = '0;
   logic [35:0] tw_ppn = '0;
   logic [2:0]  tw_rights = '0;
   logic [15:0] tw_key = '0;
   logic        pg_en = 1'b0;
   logic [15:0] pg_rid = '0;
   logic [48:0] pg_vpage = '0;
   logic        rr_we = 1'b0;
   logic [2:0]  rr_idx = '0;
   logic [15:0] rr_rid = '0;
   logic        kw_en = 1'b0;
   logic [1:0]  kw_idx = '0;
   logic        kw_valid = 1'b0;
   logic [15:0] kw_key = '0;
   logic [2:0]  kw_rights = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rtlb_top i_rtlb_top (.*);

   localparam logic [63:0] VA_A  = {3'd1, 61'h0000_0000_1234_5ABC};
   localparam logic [47:0] PA_A  = 48'h0000_0777_ABC;
   localparam logic [63:0] VA_L  = {3'd0, 61'h0000_0003_1234_5678};
   localparam logic [47:0] PA_L  = 48'h0005_1234_5678;

   task automatic check(input string req, input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic lookup(input logic [63:0] va, input logic [1:0] acc);
      @(negedge clk);
      req_valid = 1'b1;
      req_va    = va;
      req_acc   = acc;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input logic [63:0] va, input logic [1:0] acc,
                             input bit hit, input logic [1:0] flt, input logic [47:0] pa);
      lookup(va, acc);
      check("R3", rsp_valid === 1'b1, "rsp_valid", 64'(rsp_valid), 64'd1);
      check(req, rsp_hit === hit, "hit", 64'(rsp_hit), 64'(hit));
      check(req, rsp_fault === flt, "fault", 64'(rsp_fault), 64'(flt));
      if (hit) check(req, rsp_pa === pa, "pa", 64'(rsp_pa), 64'(pa));
   endtask

   task automatic put_region(input logic [2:0] idx, input logic [15:0] rid);
      @(negedge clk);
      rr_we = 1'b1; rr_idx = idx; rr_rid = rid;
      @(negedge clk);
      rr_we = 1'b0;
   endtask

   task automatic put_entry(input logic [15:0] rid, input logic [48:0] vp, input logic [5:0] ps,
                            input logic [35:0] ppn, input logic [2:0] rgt, input logic [15:0] key);
      @(negedge clk);
      tw_en = 1'b1; tw_rid = rid; tw_vpage = vp; tw_ps = ps;
      tw_ppn = ppn; tw_rights = rgt; tw_key = key;
      @(negedge clk);
      tw_en = 1'b0;
   endtask

   task automatic put_key(input logic [1:0] idx, input bit v, input logic [15:0] key,
                          input logic [2:0] rgt);
      @(negedge clk);
      kw_en = 1'b1; kw_idx = idx; kw_valid = v; kw_key = key; kw_rights = rgt;
      @(negedge clk);
      kw_en = 1'b0;
   endtask

   task automatic do_purge(input logic [15:0] rid, input logic [48:0] vp);
      @(negedge clk);
      pg_en = 1'b1; pg_rid = rid; pg_vpage = vp;
      @(negedge clk);
      pg_en = 1'b0;
   endtask

   task automatic t_reset;
      check("R11", rsp_valid === 1'b0, "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      // Empty array: any lookup misses (R11, R4)
      expect_rsp("R11", VA_A, 2'd0, 1'b0, 2'd1, '0);
      @(negedge clk);
      check("R3", rsp_valid === 1'b0, "no response without request", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_basic;
      put_region(3'd1, 16'h00AB);
      put_region(3'd0, 16'h0010);
      put_entry(16'h00AB, 49'h12345, 6'd12, 36'h777, 3'b011, 16'h0005);   // slot 0
      put_entry(16'h0010, 49'h300000, 6'd32, 36'h500000, 3'b111, 16'h0009); // slot 1
      expect_rsp("R1", VA_A, 2'd0, 1'b1, 2'd0, PA_A);
      expect_rsp("R5", VA_A, 2'd1, 1'b1, 2'd0, PA_A);
      expect_rsp("R5", VA_A, 2'd2, 1'b1, 2'd3, PA_A);
      expect_rsp("R5", VA_A, 2'd3, 1'b1, 2'd0, PA_A);
      // Large page: offset bits up to 31 come from the VA
      expect_rsp("R2", VA_L, 2'd2, 1'b1, 2'd0, PA_L);
      // Neighbouring 4 KB page misses
      expect_rsp("R2", {3'd1, 61'h0000_0000_1234_6ABC}, 2'd0, 1'b0, 2'd1, '0);
   endtask

   task automatic t_region;
      // Region 2 still holds ID 0: no entry for it (R1)
      expect_rsp("R1", {3'd2, VA_A[60:0]}, 2'd0, 1'b0, 2'd1, '0);
      put_region(3'd2, 16'h00AB);
      expect_rsp("R8", {3'd2, VA_A[60:0]}, 2'd1, 1'b1, 2'd0, PA_A);
   endtask

   task automatic t_keys;
      key_chk_en = 1'b1;
      expect_rsp("R6", VA_A, 2'd0, 1'b1, 2'd2, PA_A);
      // Translation miss takes priority over key miss (R4)
      expect_rsp("R4", {3'd3, VA_A[60:0]}, 2'd0, 1'b0, 2'd1, '0);
      put_key(2'd0, 1'b1, 16'h0005, 3'b010);   // write only
      expect_rsp("R6", VA_A, 2'd0, 1'b1, 2'd3, PA_A);
      expect_rsp("R6", VA_A, 2'd1, 1'b1, 2'd0, PA_A);
      put_key(2'd0, 1'b0, 16'h0005, 3'b111);   // invalid register no longer matches
      expect_rsp("R6", VA_A, 2'd1, 1'b1, 2'd2, PA_A);
      // Key from region ID 0x00AB, register grants read only
      key_from_region = 1'b1;
      put_key(2'd1, 1'b1, 16'h00AB, 3'b001);
      expect_rsp("R7", VA_A, 2'd0, 1'b1, 2'd0, PA_A);
      expect_rsp("R7", VA_A, 2'd1, 1'b1, 2'd3, PA_A);
      key_from_region = 1'b0;
      expect_rsp("R7", VA_A, 2'd0, 1'b1, 2'd2, PA_A);
      key_chk_en = 1'b0;
   endtask

   task automatic t_purge;
      do_purge(16'h00AB, 49'h12345);
      expect_rsp("R10", VA_A, 2'd0, 1'b0, 2'd1, '0);
      expect_rsp("R10", VA_L, 2'd0, 1'b1, 2'd0, PA_L);
   endtask

   task automatic t_round_robin;
      // Slots 0 and 1 used; eight more writes fill 2..7 then wrap to 0 and 1
      for (int k = 0; k < 8; k++)
         put_entry(16'h00AB, 49'(32'h100 + k), 6'd12, 36'(32'h200 + k), 3'b111, 16'h0);
      expect_rsp("R9", VA_L, 2'd0, 1'b0, 2'd1, '0);
      expect_rsp("R9", {3'd1, 49'h100, 12'h010}, 2'd0, 1'b1, 2'd0, {36'h200, 12'h010});
      expect_rsp("R9", {3'd1, 49'h107, 12'hFFF}, 2'd2, 1'b1, 2'd0, {36'h207, 12'hFFF});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_region();
      t_keys();
      t_purge();
      t_round_robin();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule